// File: doc/BRIEF.md
# Strobe-Ordered Backplane Bus Master

This block carries single reads and writes from a synchronous local port onto a backplane bus that has no clock. On that bus each step of a transfer is marked by one control line changing level, so the master moves through a fixed order. It sets the direction line, the address and the address modifier. It then asserts the data strobes, which also select the transfer width, and after that the address strobe. The slave's acknowledge comes back on another line. The master then releases the address group, then the data strobes, and reports the result on the local port.

Control lines are active low and are released, not driven high. Each bus output is therefore an output-enable, where 1 pulls the line low. The acknowledge and bus-error lines come in as raw active-low levels and pass through two-flop synchronizers. A programmable counter limits how long the master waits for the acknowledge. When the limit is reached, or when a slave drives the bus-error line, the cycle is aborted and reported as an error with all-ones read data. A new transfer starts only after the previous acknowledge has been seen released.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset every bus output-enable is 0, `rsp_done` is 0 and `req_ready` is 1 while both bus inputs are released (high).
- R2: In every transfer `bus_addr_oe` (address and modifier) rises at least one cycle before `bus_ds_oe` becomes nonzero, and `bus_ds_oe` is nonzero at least one cycle before `bus_as_oe` rises. While `bus_as_oe` is 1, the address and modifier outputs equal the request.
- R3: A read leaves `bus_write_oe` and `bus_data_oe` at 0. A write holds `bus_write_oe` and `bus_data_oe` at 1 from the address phase through the acknowledge, and `bus_data_o` carries the write data with the bits above the width cleared.
- R4: `req_size` 0 is a byte, 1 is 16 bits, and 2 or 3 is 32 bits. A byte with address bit 0 clear gives `bus_ds_oe`=2'b10, and with bit 0 set gives 2'b01. Wider sizes give 2'b11. `bus_lword_oe` is 1 only for 32-bit transfers.
- R5: After the acknowledge is seen, there is one cycle in which the address strobe, address and modifier are released while the data strobes are still held. In the next cycle all bus enables are 0.
- R6: On a completed transfer `rsp_done` is 1 for exactly one cycle with `rsp_err`=0. For a read, `rsp_rdata` then holds the bus data sampled at the acknowledge, zero-extended above the width.
- R7: If no acknowledge arrives, `bus_as_oe` stays 1 for exactly `timeout_limit`+1 cycles. The cycle then ends with `rsp_done`=1, `rsp_err`=1, `rsp_rdata` all ones and every bus enable at 0.
- R8: A slave-driven bus-error input during the wait aborts the cycle in the same way as R7, with `rsp_err`=1 and all-ones read data.
- R9: While the synchronized acknowledge is still low, `req_ready` is 0 and a pending request does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timeout_limit | input | TMO_W | Wait cycles allowed beyond the first before abort |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and bus acknowledge released |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| req_addr | input | ADDR_W | Transfer address |
| req_am | input | AM_W | Address modifier code |
| req_wdata | input | 32 | Write data, low-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an abort |
| rsp_rdata | output | 32 | Read data, all ones on abort |
| bus_write_oe | output | 1 | Pull direction line low (write) |
| bus_addr_oe | output | 1 | Drive address and modifier |
| bus_addr_o | output | ADDR_W | Address value |
| bus_am_o | output | AM_W | Modifier value |
| bus_lword_oe | output | 1 | Pull long-word line low |
| bus_ds_oe | output | 2 | Pull data strobes low |
| bus_as_oe | output | 1 | Pull address strobe low |
| bus_data_oe | output | 1 | Drive data lines |
| bus_data_o | output | 32 | Write data value |
| bus_data_i | input | 32 | Data seen on the bus |
| bus_dtack_n_i | input | 1 | Raw acknowledge, active low |
| bus_berr_n_i | input | 1 | Raw bus error, active low |

## Verification
Random reads and writes over all three widths, both byte offsets, random modifiers and acknowledge delays of zero to four cycles check the strobe order, the lane encoding and the masking of the data. A write that ran as a read, or a byte that ran as a word, shows up there. Directed cases let the acknowledge never arrive, with limits of 0, 3 and 255. These pin the abort to the exact cycle count, which an off-by-one counter fails. A slave bus error shows the abort path apart from the timeout path. A held acknowledge with a request waiting shows whether the release interlock works.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DRIVE, ST_DSTRB, ST_WAIT, ST_ACK, ST_FIN, ST_ABORT
  } seq_state_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] strobe_sel(input logic [1:0] sz, input logic a0);
    if (sz == 2'd0) strobe_sel = a0 ? 2'b01 : 2'b10;
    else            strobe_sel = 2'b11;
  endfunction
endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
  parameter int   W       = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= RST_VAL;
          s2 <= RST_VAL;
        end else begin
          s1 <= d[b];
          s2 <= s1;
        end
      end
      assign q[b] = s2;
    end
  endgenerate
endmodule

// File: rtl/sbm_timer.sv
module sbm_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == limit);
endmodule

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int AM_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AM_W-1:0]   req_am,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ack_n_s,
  input  logic              berr_n_s,
  input  logic              expired,
  output logic              timer_clr,
  output logic              timer_en,
  output logic              bus_write_oe,
  output logic              bus_addr_oe,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [AM_W-1:0]   bus_am_o,
  output logic              bus_lword_oe,
  output logic [1:0]        bus_ds_oe,
  output logic              bus_as_oe,
  output logic              bus_data_oe,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_data_i
);
  seq_state_t        st_q, st_d;
  logic              wr_q;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AM_W-1:0]   am_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic              accept, capture, abort;

  assign req_ready = (st_q == ST_IDLE) && ack_n_s && berr_n_s;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d      = st_q;
    timer_clr = 1'b0;
    timer_en  = 1'b0;
    capture   = 1'b0;
    abort     = 1'b0;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_DRIVE;
      ST_DRIVE: st_d = ST_DSTRB;
      ST_DSTRB: begin
        st_d      = ST_WAIT;
        timer_clr = 1'b1;
      end
      ST_WAIT: begin
        if (!ack_n_s) begin
          st_d    = ST_ACK;
          capture = 1'b1;
        end else if (!berr_n_s || expired) begin
          st_d  = ST_ABORT;
          abort = 1'b1;
        end else begin
          timer_en = 1'b1;
        end
      end
      ST_ACK:   st_d = ST_FIN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (capture)    rdata_d = bus_data_i & size_mask(sz_q);
    else if (abort) rdata_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      sz_q    <= 2'd0;
      addr_q  <= '0;
      am_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      if (accept) begin
        wr_q    <= req_write;
        sz_q    <= req_size;
        addr_q  <= req_addr;
        am_q    <= req_am;
        wdata_q <= req_wdata & size_mask(req_size);
      end
    end
  end

  logic addr_phase, strobe_phase, dir_phase;
  assign addr_phase   = (st_q == ST_DRIVE) || (st_q == ST_DSTRB) || (st_q == ST_WAIT);
  assign strobe_phase = (st_q == ST_DSTRB) || (st_q == ST_WAIT) || (st_q == ST_ACK);
  assign dir_phase    = addr_phase || (st_q == ST_ACK);

  assign bus_addr_oe  = addr_phase;
  assign bus_addr_o   = addr_q;
  assign bus_am_o     = am_q;
  assign bus_lword_oe = addr_phase && sz_q[1];
  assign bus_write_oe = dir_phase && wr_q;
  assign bus_data_oe  = dir_phase && wr_q;
  assign bus_data_o   = wdata_q;
  assign bus_ds_oe    = strobe_phase ? strobe_sel(sz_q, addr_q[0]) : 2'b00;
  assign bus_as_oe    = (st_q == ST_WAIT);

  assign rsp_done  = (st_q == ST_FIN) || (st_q == ST_ABORT);
  assign rsp_err   = (st_q == ST_ABORT);
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int AM_W   = 6,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AM_W-1:0]   req_am,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              bus_write_oe,
  output logic              bus_addr_oe,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [AM_W-1:0]   bus_am_o,
  output logic              bus_lword_oe,
  output logic [1:0]        bus_ds_oe,
  output logic              bus_as_oe,
  output logic              bus_data_oe,
  output logic [31:0]       bus_data_o,
  input  logic [31:0]       bus_data_i,
  input  logic              bus_dtack_n_i,
  input  logic              bus_berr_n_i
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              timer_clr, timer_en, expired;

  assign raw_in = {bus_berr_n_i, bus_dtack_n_i};

  sbm_sync #(.W(SYNC_W), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  sbm_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .en(timer_en),
    .limit(timeout_limit), .expired(expired)
  );

  sbm_seq #(.ADDR_W(ADDR_W), .AM_W(AM_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_am(req_am),
    .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ack_n_s(sync_out[0]), .berr_n_s(sync_out[1]), .expired(expired),
    .timer_clr(timer_clr), .timer_en(timer_en),
    .bus_write_oe(bus_write_oe), .bus_addr_oe(bus_addr_oe),
    .bus_addr_o(bus_addr_o), .bus_am_o(bus_am_o),
    .bus_lword_oe(bus_lword_oe), .bus_ds_oe(bus_ds_oe),
    .bus_as_oe(bus_as_oe), .bus_data_oe(bus_data_oe),
    .bus_data_o(bus_data_o), .bus_data_i(bus_data_i)
  );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        bus_write_oe,
  input logic        bus_addr_oe,
  input logic        bus_lword_oe,
  input logic [1:0]  bus_ds_oe,
  input logic        bus_as_oe,
  input logic        bus_data_oe
);
  AST_AS_HAS_DS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_oe |-> (bus_ds_oe != 2'b00)); // R2
  AST_DS_BEFORE_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_oe) |-> $past(bus_ds_oe != 2'b00)); // R2
  AST_AS_HAS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_oe |-> bus_addr_oe); // R2
  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> bus_write_oe); // R3
  AST_LWORD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lword_oe && bus_ds_oe != 2'b00) |-> (bus_ds_oe == 2'b11)); // R4
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!bus_as_oe && !bus_addr_oe && bus_ds_oe == 2'b00)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R6
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_rdata == 32'hFFFF_FFFF)); // R7
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_addr_oe) |-> $past(req_ready)); // R9
endmodule

bind strobe_bus_master sbm_checker u_sbm_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_write_oe(bus_write_oe),
  .bus_addr_oe(bus_addr_oe), .bus_lword_oe(bus_lword_oe),
  .bus_ds_oe(bus_ds_oe), .bus_as_oe(bus_as_oe), .bus_data_oe(bus_data_oe)
);

// File: tb/test_strobe_bus_master.sv
module test_strobe_bus_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  timeout_limit;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [5:0]  req_am;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic        bus_write_oe, bus_addr_oe, bus_lword_oe, bus_as_oe, bus_data_oe;
  logic [31:0] bus_addr_o, bus_data_o, bus_data_i;
  logic [5:0]  bus_am_o;
  logic [1:0]  bus_ds_oe;
  logic        bus_dtack_n_i, bus_berr_n_i;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_bus_master i_strobe_bus_master (
    .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_am(req_am),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_write_oe(bus_write_oe),
    .bus_addr_oe(bus_addr_oe), .bus_addr_o(bus_addr_o), .bus_am_o(bus_am_o),
    .bus_lword_oe(bus_lword_oe), .bus_ds_oe(bus_ds_oe), .bus_as_oe(bus_as_oe),
    .bus_data_oe(bus_data_oe), .bus_data_o(bus_data_o),
    .bus_data_i(bus_data_i), .bus_dtack_n_i(bus_dtack_n_i),
    .bus_berr_n_i(bus_berr_n_i)
  );

  function automatic logic [31:0] exp_mask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [1:0] exp_ds(input logic [1:0] sz, input logic a0);
    return (sz == 2'd0) ? (a0 ? 2'b01 : 2'b10) : 2'b11;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: acknowledge after dly cycles of address strobe, 1: no answer, 2: slave bus error
  task automatic run_access(input logic wr, input logic [31:0] addr,
                            input logic [5:0] am, input logic [1:0] sz,
                            input logic [31:0] wd, input logic [31:0] rd,
                            input int mode, input int dly, input int lim,
                            input int hold);
    bit seen_addr = 0, seen_ds = 0, seen_as = 0, order_ok = 1;
    bit acked = 0, rel_first = 0, done = 0, wr_seen = 0, free_ok = 0, rdy_ok = 1;
    bit got_err = 0;
    logic [31:0] got_rd = '0;
    int as_cnt = 0;
    timeout_limit = lim[7:0];
    for (int w = 0; w < 50 && !req_ready; w++) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_am = am;
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && !done; i++) begin
      if (bus_ds_oe != 2'b00 && !seen_ds) begin
        if (!seen_addr) order_ok = 0;
        seen_ds = 1;
      end
      if (bus_as_oe && !seen_as) begin
        if (!seen_ds) order_ok = 0;
        seen_as = 1;
        check(bus_addr_o == addr, "R2 address", bus_addr_o, addr);
        check(bus_am_o == am, "R2 modifier", {26'd0, bus_am_o}, {26'd0, am});
        check(bus_ds_oe == exp_ds(sz, addr[0]), "R4 strobes",
              {30'd0, bus_ds_oe}, {30'd0, exp_ds(sz, addr[0])});
        check(bus_lword_oe == sz[1], "R4 long-word", {31'd0, bus_lword_oe}, {31'd0, sz[1]});
        check(bus_data_oe == wr, "R3 data enable", {31'd0, bus_data_oe}, {31'd0, wr});
        if (wr) check(bus_data_o == (wd & exp_mask(sz)), "R3 write data",
                      bus_data_o, wd & exp_mask(sz));
      end
      if (bus_addr_oe && !seen_addr) begin
        seen_addr = 1;
        wr_seen = bus_write_oe;
      end
      if (bus_as_oe) as_cnt++;
      if (acked && !bus_as_oe && !bus_addr_oe && bus_ds_oe != 2'b00) rel_first = 1;
      if (rsp_done) begin
        done = 1;
        got_err = rsp_err;
        got_rd = rsp_rdata;
        free_ok = !bus_as_oe && !bus_addr_oe && bus_ds_oe == 2'b00 &&
                  !bus_write_oe && !bus_data_oe && !bus_lword_oe;
        if (hold == 0) begin
          bus_dtack_n_i = 1'b1;
          bus_berr_n_i  = 1'b1;
        end
      end else if (bus_as_oe && !acked && as_cnt > dly && mode != 1) begin
        acked = 1;
        bus_data_i = rd;
        if (mode == 0) bus_dtack_n_i = 1'b0;
        else           bus_berr_n_i  = 1'b0;
      end
      if (!done) @(negedge clk);
    end
    check(done, "R6 completion seen", {31'd0, done}, 32'd1);
    check(order_ok, "R2 strobe order", {31'd0, order_ok}, 32'd1);
    check(wr_seen == wr, "R3 direction line", {31'd0, wr_seen}, {31'd0, wr});
    check(free_ok, "R5 lines released at done", {31'd0, free_ok}, 32'd1);
    if (mode == 0) begin
      check(got_err == 1'b0, "R6 error flag", {31'd0, got_err}, 32'd0);
      check(rel_first, "R5 address before strobes", {31'd0, rel_first}, 32'd1);
      if (!wr) check(got_rd == (rd & exp_mask(sz)), "R6 read data",
                     got_rd, rd & exp_mask(sz));
    end else begin
      check(got_err == 1'b1, mode == 1 ? "R7 error flag" : "R8 error flag",
            {31'd0, got_err}, 32'd1);
      check(got_rd == 32'hFFFF_FFFF, mode == 1 ? "R7 ones" : "R8 ones",
            got_rd, 32'hFFFF_FFFF);
      if (mode == 1) check(as_cnt == lim + 1, "R7 strobe cycles", as_cnt, lim + 1);
    end
    @(negedge clk);
    check(rsp_done == 1'b0, "R6 single pulse", {31'd0, rsp_done}, 32'd0);
    if (hold > 0) begin
      req_valid = 1'b1;
      for (int h = 0; h < hold; h++) begin
        if (req_ready || bus_addr_oe) rdy_ok = 0;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check(rdy_ok, "R9 held acknowledge blocks start", {31'd0, rdy_ok}, 32'd1);
      bus_dtack_n_i = 1'b1;
      bus_berr_n_i  = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r_a, r_d, r_w;
    int seed_dummy;
    rst_n = 1'b0; timeout_limit = 8'd20; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'd0; req_addr = '0; req_am = '0; req_wdata = '0;
    bus_data_i = '0; bus_dtack_n_i = 1'b1; bus_berr_n_i = 1'b1;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!bus_as_oe && !bus_addr_oe && bus_ds_oe == 2'b00 && !bus_write_oe &&
          !bus_data_oe && !bus_lword_oe, "R1 enables idle",
          {26'd0, bus_as_oe, bus_addr_oe, bus_ds_oe, bus_write_oe, bus_data_oe}, 32'd0);
    check(rsp_done == 1'b0, "R1 done low", {31'd0, rsp_done}, 32'd0);
    check(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);

    // directed cases
    run_access(1'b0, 32'h0000_1000, 6'h39, 2'd2, 32'h0, 32'hCAFE_F00D, 0, 0, 20, 0);
    run_access(1'b1, 32'h0000_2003, 6'h29, 2'd0, 32'h1234_56A5, 32'h0, 0, 2, 20, 0);
    run_access(1'b0, 32'h0000_2002, 6'h3D, 2'd0, 32'h0, 32'h8765_4321, 0, 1, 20, 0);
    run_access(1'b0, 32'h00AB_0004, 6'h09, 2'd1, 32'h0, 32'hDEAD_BEEF, 0, 3, 20, 0);
    run_access(1'b0, 32'h0000_3000, 6'h39, 2'd2, 32'h0, 32'h0, 1, 0, 3, 0);   // R7
    run_access(1'b1, 32'h0000_3004, 6'h39, 2'd1, 32'hFFFF_0F0F, 32'h0, 1, 0, 0, 0); // R7 limit 0
    run_access(1'b0, 32'h0000_3008, 6'h0B, 2'd2, 32'h0, 32'h0, 1, 0, 255, 0); // R7 max limit
    run_access(1'b0, 32'h0000_4000, 6'h39, 2'd2, 32'h0, 32'h1111_2222, 2, 1, 20, 0); // R8
    run_access(1'b1, 32'h0000_5000, 6'h39, 2'd3, 32'hA5A5_5A5A, 32'h0, 0, 0, 20, 6); // R9
    run_access(1'b0, 32'h0000_5004, 6'h39, 2'd2, 32'h0, 32'h0F0F_F0F0, 0, 0, 20, 0);

    // random traffic
    for (int n = 0; n < 40; n++) begin
      r_a = $urandom; r_d = $urandom; r_w = $urandom;
      run_access(r_w[0], r_a, r_d[5:0], r_w[2:1], r_w, r_d,
                 (r_a[31:28] == 4'h0) ? 2 : 0, int'(r_a[27:25] % 5),
                 int'(r_d[31:29]) + 8, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule